// File: doc/BRIEF.md
# Keyed 64-Bit Watchdog Timer

This block is a memory-mapped watchdog built around a 64-bit up-counter. A plain 32-bit register bus gives software access to it. The bus has an address, write data, a write strobe, a read strobe and registered read data. Software sets a 64-bit compare value as two 32-bit halves, releases the two counter halves and picks a run mode. It then arms the watchdog by writing two magic keys in order. Once armed, the configuration is frozen, and the only way to keep the system alive is to repeat the same key pair before the counter reaches the compare value.

The key logic is a five-state machine:
- `WD_DISARMED`: the state after reset. Configuration is open.
- `WD_PREARM`: the first arming key has been accepted.
- `WD_ACTIVE`: armed and counting toward expiry.
- `WD_SVC_HALF`: armed, and the first half of a service pair has been seen.
- `WD_TRIPPED`: expired. Only a system reset leaves this state.

The transitions are:
- **arm-1**: DISARMED to PREARM.
- **arm-2**: PREARM to ACTIVE.
- **svc-open**: ACTIVE to SVC_HALF.
- **svc-close**: SVC_HALF to ACTIVE. This clears the counter.
- **svc-abandon**: SVC_HALF to ACTIVE on any other key.
- **expire**: ACTIVE or SVC_HALF to TRIPPED.

In TRIPPED the block drives a sticky reset request.

Top module: `keyguard_wdt`

## Requirements
- R1: After reset, `reset_req` is 0. The counter, compare, mode, release and enable registers all read 0. The identity word at 0x00 reads the `ID_VALUE` parameter.
- R2: Register map (byte addresses):
  - 0x00: identity, read-only.
  - 0x04: reserved, reads 0.
  - 0x10 and 0x14: counter low and high halves.
  - 0x18 and 0x1C: compare low and high halves.
  - 0x20: run mode in bits [7:6].
  - 0x24: bit 0 releases the low half, bit 1 releases the high half, bits [3:2] hold the mode code.
  - 0x28: bit 14 is the enable, bit 15 is the expiry flag, and bits [31:16] are the key field, which reads as 0.
  - Bits outside these fields read 0.
- R3: The counter is held at 0 while 0x24 bit 0 or bit 1 is 0, or while the run mode is 0.
- R4: When running, the counter adds 1 per clock across all 64 bits, carrying from the low half into the high half. While disarmed, it behaves as follows on reaching the compare value: run mode 1 stops it there; run mode 2 or 3 returns it to 0 on the next clock.
- R5: A write to 0x28 with key 0xA5C6 and bit 14 set moves DISARMED to PREARM. A following key 0xDA7E with bit 14 set moves it to ACTIVE. A key without bit 14, or any other key value, leaves the state unchanged.
- R6: In every state except DISARMED, writes to 0x10 through 0x28 do not change any stored register. The key field still steers the state machine.
- R7: While armed, a 0xA5C6 key write followed by a 0xDA7E key write clears the counter on the clock of the second write, whatever bit 14 holds. A read issued directly after it returns 0.
- R8: A 0xDA7E key that does not come directly after 0xA5C6 does not clear the counter. A key other than 0xDA7E or 0xA5C6 after 0xA5C6 abandons the pair. A repeated 0xA5C6 keeps the pair open.
- R9: While armed and running, the clock on which the counter equals the compare value moves the block to TRIPPED. That same clock raises `reset_req` and 0x28 bit 15. Both stay set, whatever the bus does, until `rst_n`.
- R10: A read strobe captures the addressed word into `bus_rdata` on the next clock. The counter halves read their live value. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the strobe |
| reset_req | output | 1 | Sticky system reset request raised on expiry |

## Verification
The bench aims at the key sequencing edges:
- A lone second key, which a design that ignored ordering would treat as a service.
- A stray key between the two halves, which a design keeping the half-open state would still accept.
- A key without the enable bit, which a careless decoder would use to arm.

It checks that every configuration register is frozen from the first arming key on, not only once fully armed. It measures the expiry to the exact cycle after a service, which catches an off-by-one compare or an extra output register. It also checks that keys written after expiry cannot clear the reset request. On the counter side, it covers the carry from the low half into the high half and the difference between stopping at the compare value and returning to 0.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;

    typedef enum logic [2:0] {
        WD_DISARMED,
        WD_PREARM,
        WD_ACTIVE,
        WD_SVC_HALF,
        WD_TRIPPED
    } wd_state_e;

    localparam logic [15:0] KEY_OPEN  = 16'hA5C6;
    localparam logic [15:0] KEY_CLOSE = 16'hDA7E;

    localparam int OFS_IDENT  = 'h00;
    localparam int OFS_EMU    = 'h04;
    localparam int OFS_CNT_LO = 'h10;
    localparam int OFS_CNT_HI = 'h14;
    localparam int OFS_CMP_LO = 'h18;
    localparam int OFS_CMP_HI = 'h1C;
    localparam int OFS_RUN    = 'h20;
    localparam int OFS_GLB    = 'h24;
    localparam int OFS_WDC    = 'h28;

    localparam int WDC_EN_BIT   = 14;
    localparam int WDC_FLAG_BIT = 15;
    localparam int KEY_W        = 16;

endpackage

// File: rtl/kg_regbank.sv
module kg_regbank
    import keyguard_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter logic [31:0] ID_VALUE = 32'h5744_0001
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  we,
    input  logic                  re,
    input  logic                  locked,
    input  logic                  tripped,
    input  logic [2*DATA_W-1:0]   count,
    output logic [2*DATA_W-1:0]   period,
    output logic [1:0]            run_mode,
    output logic                  rel_lo,
    output logic                  rel_hi,
    output logic [1:0]            cnt_wr,
    output logic                  key_wr,
    output logic [KEY_W-1:0]      key_val,
    output logic                  key_en,
    output logic [DATA_W-1:0]     rdata
);
    localparam int HALVES = 2;

    logic              cfg_wr;
    logic [1:0]        mode_q;
    logic [3:0]        glb_q;
    logic              en_q;
    logic [DATA_W-1:0] rmux;

    assign cfg_wr  = we && !locked;
    assign key_wr  = we && (addr == ADDR_W'(OFS_WDC));
    assign key_val = wdata[DATA_W-1 -: KEY_W];
    assign key_en  = wdata[WDC_EN_BIT];

    generate
        for (genvar h = 0; h < HALVES; h++) begin : g_half
            localparam int CMP_OFS = OFS_CMP_LO + 4 * h;
            localparam int CNT_OFS = OFS_CNT_LO + 4 * h;
            logic [DATA_W-1:0] cmp_r;

            always_ff @(posedge clk) begin
                if (!rst_n)
                    cmp_r <= '0;
                else if (cfg_wr && addr == ADDR_W'(CMP_OFS))
                    cmp_r <= wdata;
            end

            assign period[h*DATA_W +: DATA_W] = cmp_r;
            assign cnt_wr[h] = cfg_wr && (addr == ADDR_W'(CNT_OFS));

            // R6
            cmp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (locked && we && addr == ADDR_W'(CMP_OFS)) |=> $stable(cmp_r));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            glb_q  <= '0;
            en_q   <= 1'b0;
        end else if (cfg_wr) begin
            if (addr == ADDR_W'(OFS_RUN)) mode_q <= wdata[7:6];
            if (addr == ADDR_W'(OFS_GLB)) glb_q  <= wdata[3:0];
            if (addr == ADDR_W'(OFS_WDC)) en_q   <= wdata[WDC_EN_BIT];
        end
    end

    assign run_mode = mode_q;
    assign rel_lo   = glb_q[0];
    assign rel_hi   = glb_q[1];

    always_comb begin
        rmux = '0;
        case (addr)
            ADDR_W'(OFS_IDENT):  rmux = DATA_W'(ID_VALUE);
            ADDR_W'(OFS_EMU):    rmux = '0;
            ADDR_W'(OFS_CNT_LO): rmux = count[DATA_W-1:0];
            ADDR_W'(OFS_CNT_HI): rmux = count[2*DATA_W-1:DATA_W];
            ADDR_W'(OFS_CMP_LO): rmux = period[DATA_W-1:0];
            ADDR_W'(OFS_CMP_HI): rmux = period[2*DATA_W-1:DATA_W];
            ADDR_W'(OFS_RUN):    rmux[7:6] = mode_q;
            ADDR_W'(OFS_GLB):    rmux[3:0] = glb_q;
            ADDR_W'(OFS_WDC): begin
                rmux[WDC_EN_BIT]   = en_q;
                rmux[WDC_FLAG_BIT] = tripped;
            end
            default:             rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (re)
            rdata <= rmux;
    end

endmodule

// File: rtl/kg_counter.sv
module kg_counter #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                oneshot,
    input  logic                armed,
    input  logic                tripped,
    input  logic                svc_clr,
    input  logic [1:0]          cnt_wr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [2*DATA_W-1:0] period,
    output logic [2*DATA_W-1:0] count,
    output logic                at_period
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    assign at_period = (cnt_q == period);
    assign count     = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (svc_clr || !run)
            cnt_d = '0;
        else if (cnt_wr[0])
            cnt_d[DATA_W-1:0] = wdata;
        else if (cnt_wr[1])
            cnt_d[CNT_W-1:DATA_W] = wdata;
        else if (tripped)
            cnt_d = cnt_q;
        else if (at_period)
            cnt_d = (armed || oneshot) ? cnt_q : '0;
        else
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // R7
    svc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_clr |=> (count == '0));

    // R3
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == '0));

endmodule

// File: rtl/kg_keyfsm.sv
module kg_keyfsm
    import keyguard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    input  logic             key_en,
    input  logic             match,
    output logic             locked,
    output logic             armed,
    output logic             tripped,
    output logic             svc_clr,
    output logic             reset_req
);
    wd_state_e state_q;
    wd_state_e state_d;

    logic is_open;
    logic is_close;

    assign is_open  = key_wr && (key_val == KEY_OPEN);
    assign is_close = key_wr && (key_val == KEY_CLOSE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_DISARMED: if (is_open && key_en)  state_d = WD_PREARM;
            WD_PREARM:   if (is_close && key_en) state_d = WD_ACTIVE;
            WD_ACTIVE: begin
                if (match)        state_d = WD_TRIPPED;
                else if (is_open) state_d = WD_SVC_HALF;
            end
            WD_SVC_HALF: begin
                if (match)                  state_d = WD_TRIPPED;
                else if (is_open)           state_d = WD_SVC_HALF;
                else if (key_wr)            state_d = WD_ACTIVE;
            end
            WD_TRIPPED:  state_d = WD_TRIPPED;
            default:     state_d = WD_DISARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= WD_DISARMED;
        else
            state_q <= state_d;
    end

    always_comb begin
        locked  = (state_q != WD_DISARMED);
        armed   = (state_q == WD_ACTIVE) || (state_q == WD_SVC_HALF);
        tripped = (state_q == WD_TRIPPED);
        svc_clr = (state_q == WD_SVC_HALF) && is_close && !match;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            reset_req <= 1'b0;
        else
            reset_req <= (state_d == WD_TRIPPED);
    end

    // R9
    reset_req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> reset_req);

    // R9
    trip_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(armed));

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
    import keyguard_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter logic [31:0] ID_VALUE = 32'h5744_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_req
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] period;
    logic [1:0]       run_mode;
    logic             rel_lo;
    logic             rel_hi;
    logic [1:0]       cnt_wr;
    logic             key_wr;
    logic [KEY_W-1:0] key_val;
    logic             key_en;
    logic             locked;
    logic             armed;
    logic             tripped;
    logic             svc_clr;
    logic             at_period;
    logic             run;
    logic             oneshot;
    logic             match;

    assign run     = rel_lo && rel_hi && (run_mode != 2'd0);
    assign oneshot = (run_mode == 2'd1);
    assign match   = at_period && run;

    kg_regbank #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .ID_VALUE (ID_VALUE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .we       (bus_we),
        .re       (bus_re),
        .locked   (locked),
        .tripped  (tripped),
        .count    (count),
        .period   (period),
        .run_mode (run_mode),
        .rel_lo   (rel_lo),
        .rel_hi   (rel_hi),
        .cnt_wr   (cnt_wr),
        .key_wr   (key_wr),
        .key_val  (key_val),
        .key_en   (key_en),
        .rdata    (bus_rdata)
    );

    kg_counter #(
        .DATA_W (DATA_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .oneshot   (oneshot),
        .armed     (armed),
        .tripped   (tripped),
        .svc_clr   (svc_clr),
        .cnt_wr    (cnt_wr),
        .wdata     (bus_wdata),
        .period    (period),
        .count     (count),
        .at_period (at_period)
    );

    kg_keyfsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key_val   (key_val),
        .key_en    (key_en),
        .match     (match),
        .locked    (locked),
        .armed     (armed),
        .tripped   (tripped),
        .svc_clr   (svc_clr),
        .reset_req (reset_req)
    );

endmodule

// File: tb/keyguard_wdt_test.sv
module keyguard_wdt_test;
    localparam int CLK_NS = 10;
    localparam logic [31:0] ID_EXP = 32'h5744_0001;
    localparam int NVEC = 10;
    // {addr[7:0], write data[31:0], expected readback[31:0]}
    localparam logic [71:0] VEC [NVEC] = '{
        {8'h18, 32'h1234_5678, 32'h1234_5678},
        {8'h1C, 32'hCAFE_0001, 32'hCAFE_0001},
        {8'h20, 32'hFFFF_FFFF, 32'h0000_00C0},
        {8'h24, 32'hFFFF_FFF0, 32'h0000_0000},
        {8'h24, 32'h0000_000B, 32'h0000_000B},
        {8'h00, 32'hFFFF_FFFF, ID_EXP},
        {8'h04, 32'h1234_5678, 32'h0000_0000},
        {8'h28, 32'h0000_4000, 32'h0000_4000},
        {8'h28, 32'h0000_0000, 32'h0000_0000},
        {8'h3C, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    keyguard_wdt uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .reset_req (reset_req)
    );

    always #(CLK_NS / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic check_true(input string req, input bit ok, input logic [31:0] act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected %s", req, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int n;
        bit saw_low;
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1 reset_req", {31'b0, reset_req}, 32'h0);
        rd(8'h28, v); check("R1 control word", v, 32'h0);
        rd(8'h10, v); check("R1 counter low", v, 32'h0);
        rd(8'h18, v); check("R1 compare low", v, 32'h0);
        rd(8'h00, v); check("R1 identity", v, ID_EXP);

        // R2 / R10 register map table
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            check($sformatf("R2 R10 vector %0d", i), v, VEC[i][31:0]);
        end

        // R3 hold at zero
        wr(8'h24, 32'h0000_000A);
        wr(8'h20, 32'h0000_0080);
        repeat (10) @(negedge clk);
        rd(8'h10, v); check("R3 low half not released", v, 32'h0);
        wr(8'h24, 32'h0000_0009);
        repeat (10) @(negedge clk);
        rd(8'h10, v); check("R3 high half not released", v, 32'h0);
        wr(8'h24, 32'h0000_000B);
        wr(8'h20, 32'h0000_0000);
        repeat (10) @(negedge clk);
        rd(8'h10, v); check("R3 run mode 0", v, 32'h0);

        // R4 one-shot and continuous
        wr(8'h1C, 32'h0);
        wr(8'h18, 32'd5);
        wr(8'h20, 32'h0000_0040);
        repeat (20) @(negedge clk);
        rd(8'h10, v); check("R4 one-shot stops at compare", v, 32'd5);
        wr(8'h20, 32'h0000_0080);
        saw_low = 1'b0;
        for (int k = 0; k < 12; k++) begin
            rd(8'h10, v);
            if (v < 32'd5) saw_low = 1'b1;
            check_true("R4 continuous stays within compare", v <= 32'd5, v, "<= 5");
        end
        check_true("R4 continuous wraps to 0", saw_low, 32'h0, "a value below 5");
        wr(8'h1C, 32'd2);
        wr(8'h18, 32'd0);
        wr(8'h14, 32'd0);
        wr(8'h10, 32'hFFFF_FFF0);
        repeat (40) @(negedge clk);
        rd(8'h14, v); check("R4 carry into high half", v, 32'd1);

        // R5 arming sequence and R6 lock
        wr(8'h14, 32'd0);
        wr(8'h10, 32'd0);
        wr(8'h28, 32'hDA7E_4000);
        wr(8'h18, 32'd7);
        rd(8'h18, v); check("R5 second key alone does not arm", v, 32'd7);
        wr(8'h28, 32'hA5C6_0000);
        wr(8'h18, 32'd0);
        rd(8'h18, v); check("R5 first key without enable ignored", v, 32'd0);
        wr(8'h28, 32'hA5C6_4000);
        wr(8'h18, 32'd3);
        rd(8'h18, v); check("R6 compare locked after first key", v, 32'd0);
        wr(8'h28, 32'h1234_4000);
        wr(8'h28, 32'hDA7E_4000);
        wr(8'h20, 32'h0);
        rd(8'h20, v); check("R6 run mode locked when armed", v, 32'h0000_0080);
        wr(8'h10, 32'h0);
        rd(8'h10, v); check_true("R6 counter write ignored", v > 32'd0, v, "nonzero");
        rd(8'h28, v); check("R6 control word unchanged", v, 32'h0000_4000);

        // R7 service
        repeat (30) @(negedge clk);
        wr(8'h28, 32'hA5C6_0000);
        wr(8'h28, 32'hDA7E_0000);
        rd(8'h10, v); check("R7 service clears counter", v, 32'h0);

        // R8 bad sequences
        repeat (30) @(negedge clk);
        wr(8'h28, 32'hDA7E_0000);
        rd(8'h10, v); check_true("R8 lone second key no service", v >= 32'd30, v, ">= 30");
        wr(8'h28, 32'hA5C6_0000);
        wr(8'h28, 32'h0BAD_0000);
        wr(8'h28, 32'hDA7E_0000);
        rd(8'h10, v); check_true("R8 stray key abandons pair", v >= 32'd30, v, ">= 30");
        wr(8'h28, 32'hA5C6_0000);
        wr(8'h28, 32'hA5C6_0000);
        wr(8'h28, 32'hDA7E_0000);
        rd(8'h10, v); check("R8 repeated first key keeps pair", v, 32'h0);
        check("R5 armed with wrong key in between", {31'b0, reset_req}, 32'h0);

        // R9 expiry
        do_reset();
        wr(8'h24, 32'h0000_000B);
        wr(8'h18, 32'd100);
        wr(8'h20, 32'h0000_0080);
        wr(8'h28, 32'hA5C6_4000);
        wr(8'h28, 32'hDA7E_4000);
        wr(8'h28, 32'hA5C6_0000);
        wr(8'h28, 32'hDA7E_0000);
        n = 0;
        while (!reset_req && n < 300) begin
            @(negedge clk);
            n++;
        end
        check("R9 expiry cycle after service", n, 32'd101);
        wr(8'h28, 32'hA5C6_0000);
        wr(8'h28, 32'hDA7E_0000);
        check("R9 keys do not clear reset_req", {31'b0, reset_req}, 32'h1);
        rd(8'h28, v); check("R9 expiry flag", v, 32'h0000_C000);
        wr(8'h18, 32'd5);
        rd(8'h18, v); check("R6 compare locked after expiry", v, 32'd100);
        do_reset();
        check("R9 reset clears reset_req", {31'b0, reset_req}, 32'h0);
        rd(8'h28, v); check("R9 reset clears flag", v, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: bench did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule